// File: doc/BRIEF.md
# DRAM Row Retirement Sweeper

When a DRAM ECC error is reported, every page that shares the faulting row should be taken out of service. This block receives one error address and walks all column values of that row. For each column it puts the column number into the column field of the address and keeps all other bits. It sends the result to an external address translator and waits for the answer. It reduces the translated system address to a page frame number and asks an external page-state source whether that page is online and whether it is already poisoned. It issues a retire command only for a page that translated without error, is online and is not yet poisoned.

The translator and the page-state bookkeeping sit outside the block. The sweep runs only when the heterogeneous-mode configuration input is high. Otherwise a start finishes at once and retires nothing. Each of the three external exchanges uses the same handshake: the block raises its request or valid signal and holds it until the partner answers.

Top module: `row_retire_sweeper`

## Requirements
- R1: After reset the block is idle: `busy_o`, `done_o`, `xl_req_o`, `pg_req_o` and `rt_valid_o` are all low.
- R2: With `hetero_mode_i` low, a start accepted while idle raises `done_o` in the next cycle and issues no translation, page or retire request.
- R3: With `hetero_mode_i` high, the sweep issues one translation per column value in order 0, 1, … 31. Each `xl_addr_o` equals the captured error address with bits [5:1] replaced by the column value and every other bit kept.
- R4: At most one of `xl_req_o`, `pg_req_o` and `rt_valid_o` is high at a time. Each request stays high with a stable payload until its response (`xl_rsp_i`, `pg_rsp_i` or `rt_ready_i`) is seen in the same cycle.
- R5: A translation answered with `xl_err_i` high skips that column. No page query or retire is made for it, and the sweep continues with the next column.
- R6: The page query carries `pg_pfn_o` = translated system address shifted right by 12 (4 KiB pages).
- R7: A page reported offline (`pg_online_i` low) or already poisoned (`pg_poisoned_i` high) is skipped. Every other page produces exactly one retire command whose `rt_pfn_o` is that page frame number, held until `rt_ready_i`.
- R8: `done_o` is high for exactly one cycle, in the cycle after the exchange that finishes column 31. `busy_o` is high from the cycle after start until `done_o` falls.
- R9: A start pulse while the block is busy is ignored. The running sweep keeps its captured address and column sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, taken only while idle |
| err_addr_i | input | ADDR_W (28) | Faulting DRAM error address, captured at start |
| hetero_mode_i | input | 1 | Enables the sweep; when low, start completes with no action |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle completion pulse |
| xl_req_o | output | 1 | Translation request |
| xl_addr_o | output | ADDR_W (28) | Address with the column substituted |
| xl_rsp_i | input | 1 | Translation response strobe |
| xl_err_i | input | 1 | Translation failed (valid with `xl_rsp_i`) |
| xl_sys_i | input | SYS_W (48) | Translated system address (valid with `xl_rsp_i`) |
| pg_req_o | output | 1 | Page-status query |
| pg_pfn_o | output | SYS_W-12 (36) | Page frame number being queried |
| pg_rsp_i | input | 1 | Page-status response strobe |
| pg_online_i | input | 1 | Page is online (valid with `pg_rsp_i`) |
| pg_poisoned_i | input | 1 | Page already poisoned (valid with `pg_rsp_i`) |
| rt_valid_o | output | 1 | Retire command valid |
| rt_pfn_o | output | SYS_W-12 (36) | Page frame number to retire |
| rt_ready_i | input | 1 | Retire command accepted |

## Verification
The bench uses the default parameters: a 28-bit error address, a 5-bit column field at bit 1, 48-bit system addresses and 12-bit page offsets. With these values every one of the 32 columns can be walked in each run. The responders derive translate errors, offline pages, poisoned pages and response delays arithmetically from the column number, and several different patterns are run. This exercises every skip path, every back-to-back request and the last-column completion, and the expected page numbers and retire count are computed alongside.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
   typedef enum logic [2:0] {
      SW_IDLE,
      SW_XLATE,
      SW_CHECK,
      SW_RETIRE,
      SW_DONE
   } sweep_st_e;
endpackage

// File: rtl/rrs_col_splice.sv
module rrs_col_splice #(
   parameter int ADDR_W  = 28,
   parameter int COL_LSB = 1,
   parameter int COL_W   = 5
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [COL_W-1:0]  col_i,
   output logic [ADDR_W-1:0] addr_o
);
   localparam int COL_MSB = COL_LSB + COL_W - 1;

   for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
      if (b >= COL_LSB && b <= COL_MSB) begin : g_col
         assign addr_o[b] = col_i[b-COL_LSB];
      end else begin : g_keep
         assign addr_o[b] = base_i[b];
      end
   end
endmodule

// File: rtl/rrs_col_cursor.sv
module rrs_col_cursor #(
   parameter int COL_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             step_i,
   output logic [COL_W-1:0] col_o,
   output logic             last_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       col_o <= '0;
      else if (clear_i) col_o <= '0;
      else if (step_i)  col_o <= col_o + 1'b1;
   end

   assign last_o = &col_o;

   // R3: the cursor only moves forward by one
   p_col_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      step_i && !clear_i && !last_o |=> col_o == $past(col_o) + 1'b1);
endmodule

// File: rtl/row_retire_sweeper.sv
module row_retire_sweeper
   import rrs_pkg::*;
#(
   parameter int ADDR_W     = 28,
   parameter int SYS_W      = 48,
   parameter int COL_LSB    = 1,
   parameter int COL_W      = 5,
   parameter int PAGE_SHIFT = 12,
   localparam int PFN_W     = SYS_W - PAGE_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] err_addr_i,
   input  logic              hetero_mode_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              xl_req_o,
   output logic [ADDR_W-1:0] xl_addr_o,
   input  logic              xl_rsp_i,
   input  logic              xl_err_i,
   input  logic [SYS_W-1:0]  xl_sys_i,
   output logic              pg_req_o,
   output logic [PFN_W-1:0]  pg_pfn_o,
   input  logic              pg_rsp_i,
   input  logic              pg_online_i,
   input  logic              pg_poisoned_i,
   output logic              rt_valid_o,
   output logic [PFN_W-1:0]  rt_pfn_o,
   input  logic              rt_ready_i
);
   if (COL_LSB + COL_W > ADDR_W) begin : g_bad_col
      $error("column field does not fit in the error address");
   end
   if (PAGE_SHIFT < 1 || PAGE_SHIFT >= SYS_W) begin : g_bad_page
      $error("page shift out of range");
   end

   sweep_st_e         st_q, st_d;
   logic [ADDR_W-1:0] base_q;
   logic [PFN_W-1:0]  pfn_q;
   logic [COL_W-1:0]  col;
   logic              col_last;
   logic              accept, xl_hs, pg_hs, rt_hs, advance, keep_page;
   logic              unused_low;

   assign unused_low = ^xl_sys_i[PAGE_SHIFT-1:0];

   assign accept    = (st_q == SW_IDLE) && start_i;
   assign xl_hs     = (st_q == SW_XLATE) && xl_rsp_i;
   assign pg_hs     = (st_q == SW_CHECK) && pg_rsp_i;
   assign rt_hs     = (st_q == SW_RETIRE) && rt_ready_i;
   assign keep_page = pg_online_i && !pg_poisoned_i;
   assign advance   = (xl_hs && xl_err_i) || (pg_hs && !keep_page) || rt_hs;

   rrs_col_cursor #(.COL_W(COL_W)) u_cursor (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (accept),
      .step_i  (advance && !col_last),
      .col_o   (col),
      .last_o  (col_last)
   );

   rrs_col_splice #(.ADDR_W(ADDR_W), .COL_LSB(COL_LSB), .COL_W(COL_W)) u_splice (
      .base_i (base_q),
      .col_i  (col),
      .addr_o (xl_addr_o)
   );

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         SW_IDLE:   if (start_i) st_d = hetero_mode_i ? SW_XLATE : SW_DONE;
         SW_XLATE:  if (xl_hs && !xl_err_i) st_d = SW_CHECK;
         SW_CHECK:  if (pg_hs && keep_page) st_d = SW_RETIRE;
         SW_RETIRE: ;
         SW_DONE:   st_d = SW_IDLE;
         default:   st_d = SW_IDLE;
      endcase
      if (advance) st_d = col_last ? SW_DONE : SW_XLATE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SW_IDLE;
         base_q <= '0;
         pfn_q  <= '0;
      end else begin
         st_q <= st_d;
         if (accept) base_q <= err_addr_i;
         if (xl_hs && !xl_err_i) pfn_q <= xl_sys_i[SYS_W-1:PAGE_SHIFT];
      end
   end

   assign busy_o     = (st_q != SW_IDLE);
   assign done_o     = (st_q == SW_DONE);
   assign xl_req_o   = (st_q == SW_XLATE);
   assign pg_req_o   = (st_q == SW_CHECK);
   assign rt_valid_o = (st_q == SW_RETIRE);
   assign pg_pfn_o   = pfn_q;
   assign rt_pfn_o   = pfn_q;

   // R4: a single exchange at a time
   p_one_exchange_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({xl_req_o, pg_req_o, rt_valid_o}));
   // R4: translation request held with stable address until answered
   p_xl_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      xl_req_o && !xl_rsp_i |=> xl_req_o && $stable(xl_addr_o));
   // R7: retire command held until accepted
   p_rt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rt_valid_o && !rt_ready_i |=> rt_valid_o && $stable(rt_pfn_o));
   // R5: translate error never leads to a page query
   p_err_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
      xl_req_o && xl_rsp_i && xl_err_i |=> !pg_req_o);
   // R8: done is a single-cycle pulse
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o && !busy_o);
   // R2: no sweep without heterogeneous mode
   p_no_sweep_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !busy_o && !hetero_mode_i |=> done_o && !xl_req_o);
   // R9: start while busy does not disturb the captured address
   p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      xl_req_o && start_i && !xl_rsp_i |=> $stable(xl_addr_o));
endmodule

// File: tb/row_retire_sweeper_tb.sv
module row_retire_sweeper_tb;
   localparam int ADDR_W = 28;
   localparam int SYS_W  = 48;
   localparam int PFN_W  = SYS_W - 12;

   logic              clk = 0;
   logic              rst_n = 0;
   logic              start_i = 0;
   logic [ADDR_W-1:0] err_addr_i = '0;
   logic              hetero_mode_i = 0;
   logic              busy_o, done_o, xl_req_o, pg_req_o, rt_valid_o;
   logic [ADDR_W-1:0] xl_addr_o;
   logic              xl_rsp_i = 0, xl_err_i = 0;
   logic [SYS_W-1:0]  xl_sys_i = '0;
   logic [PFN_W-1:0]  pg_pfn_o, rt_pfn_o;
   logic              pg_rsp_i = 0, pg_online_i = 0, pg_poisoned_i = 0;
   logic              rt_ready_i = 0;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   row_retire_sweeper u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .err_addr_i(err_addr_i),
      .hetero_mode_i(hetero_mode_i), .busy_o(busy_o), .done_o(done_o),
      .xl_req_o(xl_req_o), .xl_addr_o(xl_addr_o), .xl_rsp_i(xl_rsp_i),
      .xl_err_i(xl_err_i), .xl_sys_i(xl_sys_i), .pg_req_o(pg_req_o),
      .pg_pfn_o(pg_pfn_o), .pg_rsp_i(pg_rsp_i), .pg_online_i(pg_online_i),
      .pg_poisoned_i(pg_poisoned_i), .rt_valid_o(rt_valid_o),
      .rt_pfn_o(rt_pfn_o), .rt_ready_i(rt_ready_i)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [SYS_W-1:0] sys_of(input logic [ADDR_W-1:0] a, input int c);
      return (SYS_W'(a) << 9) ^ SYS_W'(c * 37 + 1);
   endfunction

   task automatic wait_neg(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // one full sweep; pattern p shapes errors, page states and delays
   task automatic sweep(input logic [ADDR_W-1:0] addr, input int p);
      int retires = 0, exp_retires = 0;
      logic [ADDR_W-1:0] exp_a;
      logic [PFN_W-1:0] exp_pfn;
      bit e, on, poi;
      int d;
      @(negedge clk);
      err_addr_i = addr; hetero_mode_i = 1; start_i = 1;
      @(negedge clk);
      start_i = 0;
      err_addr_i = ~addr;
      chk(busy_o == 1, "R8 busy after start", busy_o, 1);
      for (int c = 0; c < 32; c++) begin
         e   = ((c + p) % 5) == 3;
         on  = ((c + p) % 3) != 1;
         poi = ((c * (p + 1)) % 4) == 2;
         d   = (c + p) % 3;
         exp_a = addr;
         exp_a[5:1] = c[4:0];
         chk(xl_req_o == 1 && !pg_req_o && !rt_valid_o, "R4 single translate request", xl_req_o, 1);
         chk(xl_addr_o == exp_a, "R3 column substituted address", xl_addr_o, exp_a);
         for (int k = 0; k < d; k++) begin
            if (c == 10 && k == 0) begin
               start_i = 1; err_addr_i = addr ^ 28'h5A5_0000;
            end
            @(negedge clk);
            start_i = 0;
            chk(xl_req_o && xl_addr_o == exp_a, "R4/R9 request held stable", xl_addr_o, exp_a);
         end
         xl_rsp_i = 1; xl_err_i = e; xl_sys_i = sys_of(exp_a, c);
         @(negedge clk);
         xl_rsp_i = 0; xl_err_i = 0; xl_sys_i = '0;
         if (e) begin
            chk(pg_req_o == 0, "R5 error column skipped", pg_req_o, 0);
         end else begin
            exp_pfn = sys_of(exp_a, c) >> 12;
            chk(pg_req_o == 1 && pg_pfn_o == exp_pfn, "R6 page number query", pg_pfn_o, exp_pfn);
            wait_neg(d);
            pg_rsp_i = 1; pg_online_i = on; pg_poisoned_i = poi;
            @(negedge clk);
            pg_rsp_i = 0; pg_online_i = 0; pg_poisoned_i = 0;
            if (on && !poi) begin
               exp_retires++;
               chk(rt_valid_o == 1 && rt_pfn_o == exp_pfn, "R7 retire issued", rt_pfn_o, exp_pfn);
               for (int k = 0; k < (c % 2); k++) begin
                  @(negedge clk);
                  chk(rt_valid_o && rt_pfn_o == exp_pfn, "R7 retire held", rt_pfn_o, exp_pfn);
               end
               rt_ready_i = 1;
               @(negedge clk);
               rt_ready_i = 0;
               retires++;
            end else begin
               chk(rt_valid_o == 0, "R7 offline or poisoned page skipped", rt_valid_o, 0);
            end
         end
         if (c < 31) chk(done_o == 0, "R8 no early done", done_o, 0);
      end
      chk(done_o == 1 && !xl_req_o, "R8 done after last column", done_o, 1);
      @(negedge clk);
      chk(done_o == 0 && busy_o == 0, "R8 done single cycle", done_o, 0);
      chk(retires == exp_retires, "R7 retire count", retires, exp_retires);
   endtask

   initial begin
      int guard = 0;
      while (!finished && guard < 150000) begin
         @(posedge clk);
         guard++;
      end
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=done", guard);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      wait_neg(3);
      rst_n = 1;
      @(negedge clk);
      chk(!busy_o && !done_o && !xl_req_o && !pg_req_o && !rt_valid_o,
          "R1 reset idle", {busy_o, done_o, xl_req_o, pg_req_o, rt_valid_o}, 0);

      // R2: heterogeneous mode off
      err_addr_i = 28'hABCDEF1; hetero_mode_i = 0; start_i = 1;
      @(negedge clk);
      start_i = 0;
      chk(done_o == 1 && !xl_req_o && !pg_req_o && !rt_valid_o, "R2 immediate done", done_o, 1);
      @(negedge clk);
      chk(done_o == 0 && !busy_o, "R2 back to idle", done_o, 0);

      sweep(28'hFFF_FFFF, 0);
      sweep(28'h000_0000, 1);
      sweep(28'h8A5_3C1E, 2);
      sweep(28'h123_4567, 3);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule